// File: doc/BRIEF.md
# Watchdog Reset Request Generator

This block sits behind a watchdog counter and converts its overflow event into system reset requests. Two channels run side by side: one drives the chip's internal reset request and one drives an external reset pin. Each channel has its own enable, its own overflow-to-request delay counted in ticks of a slow timebase, and its own output style. A held level stays until software clears it. A pulse lasts a programmed number of ticks.

The external channel also takes a polarity setting, so the pin can be active-low or active-high. A pending flag shows that a channel has seen an overflow and is counting down to its request. A restart option makes the block emit a one-cycle restart request back to the watchdog when the internal request releases.

Each channel is a four-state machine. The states are IDLE, WAIT (the delay is counting), HOLD (level request asserted) and PULSE (timed request asserted). The transitions are:

- ARM: from IDLE to WAIT, on an overflow with a nonzero delay.
- FIRE: from WAIT to HOLD or PULSE, on the tick that ends the delay. With a zero delay it runs straight from IDLE on the overflow.
- EXPIRE: from PULSE to IDLE, on the tick that ends the window.
- CANCEL: from any state to IDLE, when the channel is disabled or software clears it.

Top module: `wdog_rstreq_gen`

## Requirements
- R1: Out of reset both channels are in IDLE. The internal request is 0, the external pin sits at its inactive level (the inverse of the polarity input), and the pending and restart outputs are 0.
- R2: After an overflow on an enabled channel with delay D > 0, the request asserts on the clock edge that takes in the D-th tick after the overflow edge. A tick in the same cycle as the overflow is not counted. With D = 0 the request asserts on the overflow edge itself.
- R3: With mode 0 (level), the request stays asserted until the clear input is seen or the channel is disabled.
- R4: With mode 1 (pulse), the request stays asserted for W ticks and releases on the edge that takes in the W-th tick. A window value of 0 behaves as 1.
- R5: The external pin equals the active state when the polarity is 1 (active-high) and its inverse when the polarity is 0 (active-low). The internal request is always active-high.
- R6: A disabled channel ignores overflows and drives its inactive level at once. Disabling a channel during WAIT, HOLD or PULSE returns it to IDLE.
- R7: An overflow that arrives while a channel is in WAIT, HOLD or PULSE does not restart its delay or window.
- R8: The pending output is 1 exactly while at least one channel is in WAIT.
- R9: When the restart option is 1 in the cycle the internal request releases (by clear, disable or window end), the restart output is 1 for exactly one cycle, aligned with the release. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_i | input | 1 | Watchdog overflow event, one cycle |
| tick_i | input | 1 | Timebase tick strobe for delays and windows |
| clr_i | input | 1 | Software clear: both channels return to IDLE |
| restart_en_i | input | 1 | Enables the restart request when the internal request releases |
| int_en_i | input | 1 | Internal channel enable |
| int_mode_i | input | 1 | Internal output mode: 0 level, 1 pulse |
| int_dly_i | input | DLY_W | Internal delay in ticks from overflow to request |
| int_win_i | input | WIN_W | Internal pulse width in ticks |
| ext_en_i | input | 1 | External channel enable |
| ext_mode_i | input | 1 | External output mode: 0 level, 1 pulse |
| ext_pol_i | input | 1 | External active level: 0 low, 1 high |
| ext_dly_i | input | DLY_W | External delay in ticks from overflow to request |
| ext_win_i | input | WIN_W | External pulse width in ticks |
| int_req_o | output | 1 | Internal reset request, active-high |
| ext_req_o | output | 1 | External reset request pin, polarity per ext_pol_i |
| pending_o | output | 1 | A channel is counting toward its request |
| restart_o | output | 1 | One-cycle restart request to the watchdog |

## Verification
The bench builds the block with DLY_W = 6 and WIN_W = 4. At these widths random draws reach the all-ones delay and window values, as well as zero, so the counters' extreme loads are covered. The narrow widths also keep each delay short enough that thousands of overflow, tick, clear and disable interleavings fit in one run. These include overflows that land during WAIT, HOLD and PULSE, and clears that coincide with the final tick.

// File: rtl/wdog_rstreq_pkg.sv
package wdog_rstreq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_PULSE = 2'd3
    } chan_state_e;

    localparam int NUM_CH = 2;
    localparam int CH_INT = 0;
    localparam int CH_EXT = 1;

    localparam logic MODE_LEVEL = 1'b0;
    localparam logic MODE_PULSE = 1'b1;

endpackage

// File: rtl/wdog_rstreq_tickcnt.sv
module wdog_rstreq_tickcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         expire_o
);

    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != ZERO)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = dec_i && (cnt_q == ONE);

    // a decrement never wraps below zero
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == ZERO) |=> (cnt_q == ZERO)); // R2

endmodule

// File: rtl/wdog_rstreq_chan.sv
module wdog_rstreq_chan
    import wdog_rstreq_pkg::*;
#(
    parameter int DLY_W = 16,
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic             ovf_i,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic             active_o,
    output logic             waiting_o,
    output logic             release_o
);

    localparam logic [WIN_W-1:0] WIN_MIN  = {{(WIN_W-1){1'b0}}, 1'b1};
    localparam logic [DLY_W-1:0] DLY_ZERO = '0;
    localparam logic [WIN_W-1:0] WIN_ZERO = '0;

    chan_state_e state_q, state_nx;

    logic             dly_load, dly_dec, dly_expire;
    logic             win_load, win_dec, win_expire;
    logic [DLY_W-1:0] dly_cnt;
    logic [WIN_W-1:0] win_cnt;
    logic [WIN_W-1:0] win_eff;
    logic             cancel;
    logic             fire_now;
    chan_state_e      fire_state;

    assign cancel     = !en_i || clr_i;
    assign win_eff    = (win_i == WIN_ZERO) ? WIN_MIN : win_i;
    assign fire_state = (mode_i == MODE_PULSE) ? ST_PULSE : ST_HOLD;

    // FIRE condition: zero delay on the overflow, or the delay ends in WAIT
    always_comb begin
        fire_now = 1'b0;
        unique case (state_q)
            ST_IDLE:  fire_now = ovf_i && (dly_i == DLY_ZERO);
            ST_WAIT:  fire_now = dly_expire;
            ST_HOLD:  fire_now = 1'b0;
            ST_PULSE: fire_now = 1'b0;
            default:  fire_now = 1'b0;
        endcase
    end

    // next-state logic: ARM, FIRE, EXPIRE, CANCEL
    always_comb begin
        state_nx = state_q;
        if (cancel) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (fire_now) begin
                        state_nx = fire_state;
                    end else if (ovf_i) begin
                        state_nx = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (fire_now) begin
                        state_nx = fire_state;
                    end
                end
                ST_HOLD: begin
                    state_nx = ST_HOLD;
                end
                ST_PULSE: begin
                    if (win_expire) begin
                        state_nx = ST_IDLE;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // counter controls
    assign dly_load = (state_q == ST_IDLE) && !cancel && ovf_i;
    assign dly_dec  = (state_q == ST_WAIT) && tick_i;
    assign win_load = (state_nx == ST_PULSE) && (state_q != ST_PULSE);
    assign win_dec  = (state_q == ST_PULSE) && tick_i;

    wdog_rstreq_tickcnt #(.W(DLY_W)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (dly_load),
        .load_val_i (dly_i),
        .dec_i      (dly_dec),
        .cnt_o      (dly_cnt),
        .expire_o   (dly_expire)
    );

    wdog_rstreq_tickcnt #(.W(WIN_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (win_load),
        .load_val_i (win_eff),
        .dec_i      (win_dec),
        .cnt_o      (win_cnt),
        .expire_o   (win_expire)
    );

    // output process
    always_comb begin
        active_o  = 1'b0;
        waiting_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin active_o = 1'b0; waiting_o = 1'b0; end
            ST_WAIT:  begin active_o = 1'b0; waiting_o = 1'b1; end
            ST_HOLD:  begin active_o = en_i; waiting_o = 1'b0; end
            ST_PULSE: begin active_o = en_i; waiting_o = 1'b0; end
            default:  begin active_o = 1'b0; waiting_o = 1'b0; end
        endcase
        release_o = ((state_q == ST_HOLD) || (state_q == ST_PULSE)) &&
                    (state_nx == ST_IDLE);
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !cancel) |=> (state_q == ST_HOLD)); // R3
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !cancel && win_expire) |=> (state_q == ST_IDLE)); // R4
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (state_q == ST_IDLE)); // R6
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !cancel && !tick_i) |=> $stable(dly_cnt)); // R7
    AST_WIN_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !cancel && !tick_i) |=> $stable(win_cnt)); // R7

endmodule

// File: rtl/wdog_rstreq_drive.sv
module wdog_rstreq_drive #(
    parameter bit HAS_POL = 1'b1
) (
    input  logic active_i,
    input  logic pol_i,
    output logic req_o
);

    generate
        if (HAS_POL) begin : g_pol
            assign req_o = pol_i ? active_i : !active_i;
        end else begin : g_fixed
            logic unused_pol;
            assign unused_pol = pol_i;
            assign req_o      = active_i;
        end
    endgenerate

endmodule

// File: rtl/wdog_rstreq_gen.sv
module wdog_rstreq_gen
    import wdog_rstreq_pkg::*;
#(
    parameter int DLY_W = 16,
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovf_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             restart_en_i,
    input  logic             int_en_i,
    input  logic             int_mode_i,
    input  logic [DLY_W-1:0] int_dly_i,
    input  logic [WIN_W-1:0] int_win_i,
    input  logic             ext_en_i,
    input  logic             ext_mode_i,
    input  logic             ext_pol_i,
    input  logic [DLY_W-1:0] ext_dly_i,
    input  logic [WIN_W-1:0] ext_win_i,
    output logic             int_req_o,
    output logic             ext_req_o,
    output logic             pending_o,
    output logic             restart_o
);

    logic             ch_en   [NUM_CH];
    logic             ch_mode [NUM_CH];
    logic             ch_pol  [NUM_CH];
    logic [DLY_W-1:0] ch_dly  [NUM_CH];
    logic [WIN_W-1:0] ch_win  [NUM_CH];
    logic             ch_act  [NUM_CH];
    logic             ch_wait [NUM_CH];
    logic             ch_rel  [NUM_CH];
    logic             ch_req  [NUM_CH];
    logic             restart_q;

    assign ch_en[CH_INT]   = int_en_i;
    assign ch_mode[CH_INT] = int_mode_i;
    assign ch_pol[CH_INT]  = 1'b1;
    assign ch_dly[CH_INT]  = int_dly_i;
    assign ch_win[CH_INT]  = int_win_i;
    assign ch_en[CH_EXT]   = ext_en_i;
    assign ch_mode[CH_EXT] = ext_mode_i;
    assign ch_pol[CH_EXT]  = ext_pol_i;
    assign ch_dly[CH_EXT]  = ext_dly_i;
    assign ch_win[CH_EXT]  = ext_win_i;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            wdog_rstreq_chan #(.DLY_W(DLY_W), .WIN_W(WIN_W)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .en_i      (ch_en[c]),
                .mode_i    (ch_mode[c]),
                .dly_i     (ch_dly[c]),
                .win_i     (ch_win[c]),
                .ovf_i     (ovf_i),
                .tick_i    (tick_i),
                .clr_i     (clr_i),
                .active_o  (ch_act[c]),
                .waiting_o (ch_wait[c]),
                .release_o (ch_rel[c])
            );
            wdog_rstreq_drive #(.HAS_POL(c == CH_EXT)) u_drive (
                .active_i (ch_act[c]),
                .pol_i    (ch_pol[c]),
                .req_o    (ch_req[c])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
        end else begin
            restart_q <= restart_en_i && ch_rel[CH_INT];
        end
    end

    logic unused_ext_rel;
    assign unused_ext_rel = ch_rel[CH_EXT];

    assign int_req_o = ch_req[CH_INT];
    assign ext_req_o = ch_req[CH_EXT];
    assign pending_o = ch_wait[CH_INT] || ch_wait[CH_EXT];
    assign restart_o = restart_q;

    AST_EXT_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en_i) |-> (ext_req_o == !ext_pol_i)); // R6
    AST_INT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en_i) |-> !int_req_o); // R6
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o); // R9
    AST_RESTART_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_en_i && int_en_i && int_req_o && clr_i) |=> restart_o); // R9

endmodule

// File: tb/sim_wdog_rstreq_gen.sv
module sim_wdog_rstreq_gen;

    localparam int DW = 6;
    localparam int WW = 4;
    localparam int MI = 0, MW = 1, MH = 2, MP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovf = 0, tick = 0, clr = 0, rsen = 0;
    logic ien = 0, imode = 0, een = 0, emode = 0, epol = 0;
    logic [DW-1:0] idly = '0, edly = '0;
    logic [WW-1:0] iwin = '0, ewin = '0;
    logic int_req, ext_req, pending, restart;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_st [2];
    int m_dc [2];
    int m_wc [2];
    bit m_restart;

    always #10 clk = ~clk;

    wdog_rstreq_gen #(.DLY_W(DW), .WIN_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .ovf_i(ovf), .tick_i(tick), .clr_i(clr),
        .restart_en_i(rsen),
        .int_en_i(ien), .int_mode_i(imode), .int_dly_i(idly), .int_win_i(iwin),
        .ext_en_i(een), .ext_mode_i(emode), .ext_pol_i(epol),
        .ext_dly_i(edly), .ext_win_i(ewin),
        .int_req_o(int_req), .ext_req_o(ext_req),
        .pending_o(pending), .restart_o(restart)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_active(input int st, input bit en);
        return en && (st == MH || st == MP);
    endfunction

    function automatic bit exp_ext(input int st, input bit en, input bit pol);
        bit a;
        a = exp_active(st, en);
        return pol ? a : !a;
    endfunction

    function automatic int win_of(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    // one step of the requirement model for channel c; returns release flag
    function automatic bit model_step(input int c, input bit en, input bit mode,
                                      input int dly, input int win);
        bit rel;
        rel = 0;
        if (!en || clr) begin
            if (m_st[c] == MH || m_st[c] == MP) rel = 1;
            m_st[c] = MI;
        end else begin
            case (m_st[c])
                MI: if (ovf) begin
                    if (dly == 0) begin
                        m_st[c] = mode ? MP : MH;
                        m_wc[c] = win_of(win);
                    end else begin
                        m_st[c] = MW;
                        m_dc[c] = dly;
                    end
                end
                MW: if (tick) begin
                    if (m_dc[c] == 1) begin
                        m_st[c] = mode ? MP : MH;
                        m_wc[c] = win_of(win);
                    end else m_dc[c]--;
                end
                MP: if (tick) begin
                    if (m_wc[c] == 1) begin
                        m_st[c] = MI;
                        rel = 1;
                    end else m_wc[c]--;
                end
                default: ;
            endcase
        end
        return rel;
    endfunction

    // continuous model comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin m_st[c] = MI; m_dc[c] = 0; m_wc[c] = 0; end
            m_restart = 0;
        end else if (!done) begin
            bit r;
            chk("R2 int_req", int_req, exp_active(m_st[0], ien));
            chk("R5 ext_req", ext_req, exp_ext(m_st[1], een, epol));
            chk("R8 pending", pending, (m_st[0] == MW) || (m_st[1] == MW));
            chk("R9 restart", restart, m_restart);
            r = model_step(0, ien, imode, int'(idly), int'(iwin));
            void'(model_step(1, een, emode, int'(edly), int'(ewin)));
            m_restart = r && rsen;
        end
    end

    task automatic cyc(input bit o, input bit t, input bit c);
        @(posedge clk); #2;
        ovf = o; tick = t; clr = c;
        @(posedge clk); #2;
        ovf = 0; tick = 0; clr = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        ien = 1; imode = 0; idly = 6'd3; iwin = 4'd0;
        een = 0; emode = 0; epol = 0; edly = 6'd2; ewin = 4'd0;
        rsen = 1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(posedge clk); #2;
        // R1 reset state
        chk("R1 int_req", int_req, 1'b0);
        chk("R1 ext_req idle high", ext_req, 1'b1);
        chk("R1 pending", pending, 1'b0);
        chk("R1 restart", restart, 1'b0);

        // R2/R7: delay 3, extra overflow mid-delay
        cyc(1, 0, 0);
        chk("R8 pending after overflow", pending, 1'b1);
        cyc(0, 1, 0);
        cyc(0, 1, 0);
        chk("R2 before last tick", int_req, 1'b0);
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        chk("R7 third tick fires despite overflow", int_req, 1'b1);
        chk("R8 pending cleared", pending, 1'b0);
        // R3 level holds
        cyc(0, 1, 0);
        cyc(1, 1, 0);
        chk("R3 level holds", int_req, 1'b1);
        cyc(0, 0, 1);
        chk("R3 clear releases", int_req, 1'b0);
        chk("R9 restart on release", restart, 1'b1);
        cyc(0, 0, 0);
        chk("R9 restart one cycle", restart, 1'b0);

        // R4 pulse, zero delay, window 2
        imode = 1; idly = 0; iwin = 4'd2;
        cyc(1, 0, 0);
        chk("R2 zero delay", int_req, 1'b1);
        cyc(0, 1, 0);
        chk("R4 pulse first tick", int_req, 1'b1);
        cyc(0, 1, 0);
        chk("R4 pulse ends", int_req, 1'b0);

        // R5 external active-low pulse, window 0 acts as 1
        een = 1; epol = 0; emode = 1; edly = 6'd1; ewin = 4'd0; ien = 0;
        cyc(0, 0, 0);
        chk("R5 ext inactive high", ext_req, 1'b1);
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        chk("R5 ext active low", ext_req, 1'b0);
        cyc(0, 1, 0);
        chk("R4 ext window zero", ext_req, 1'b1);
        epol = 1;
        cyc(0, 0, 0);
        chk("R5 ext inactive low", ext_req, 1'b0);

        // R6 disabled channel ignores overflow
        een = 0;
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        cyc(0, 1, 0);
        chk("R6 int disabled", int_req, 1'b0);
        chk("R6 ext disabled", ext_req, 1'b0);
        chk("R6 no pending", pending, 1'b0);
        // R6 disable during level hold
        een = 1; emode = 0; edly = 0;
        cyc(1, 0, 0);
        chk("R6 ext held", ext_req, 1'b1);
        @(posedge clk); #2 een = 0;
        #1 chk("R6 ext drops on disable", ext_req, 1'b0);

        // random phase checked by the model
        for (int n = 0; n < 24000; n++) begin
            @(posedge clk); #2;
            if (n % 400 == 0) begin
                ien = ($urandom % 6) != 0; een = ($urandom % 6) != 0;
                imode = $urandom; emode = $urandom; epol = $urandom;
                rsen = $urandom;
                idly = ($urandom % 5 == 0) ? '0 : DW'($urandom);
                edly = ($urandom % 5 == 0) ? '1 : DW'($urandom);
                iwin = ($urandom % 4 == 0) ? '0 : WW'($urandom);
                ewin = ($urandom % 4 == 0) ? '1 : WW'($urandom);
            end
            ovf  = ($urandom % 24) == 0;
            tick = ($urandom % 2) == 0;
            clr  = ($urandom % 90) == 0;
        end
        @(posedge clk); #2;
        ovf = 0; tick = 0; clr = 0;
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, run hung");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule